// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous on-chip logic use an external asynchronous static RAM that holds 1M words of 4 bits. A client presents a one-cycle request carrying a direction flag, a 20-bit word address and, for stores, a 4-bit data nibble. The sequencer then drives the active-low chip-select, write-strobe and output-enable lines, the address bus and a split data bus: an output value, an output-enable for the pad driver and an input value. Loads return the fetched nibble with a one-cycle valid pulse.

The memory side has no clock, so every timing minimum of the memory is expressed as a whole number of controller clock cycles. The counts are parameters, rounded up from nanoseconds for the chosen clock period. One design therefore serves any speed grade. A busy flag tells the client when the next request may be presented.

Strobe combinations follow the memory's own decode. Chip-select high deselects the device. Chip-select low with the write strobe low is a store, and this block always holds output-enable high during a store. Chip-select and output-enable low with the write strobe high is a load.

Top module: `sram_ctl`

## Requirements
- R1: While reset is low, and in the first cycle after it, all three strobes are high, the data-bus output-enable is low, and busy and rd_valid are low.
- R2: A load accepted at clock edge n holds chip-select and output-enable low, with the write strobe high and the address equal to the request, from edge n to edge n+T_ACC. The nibble present on mem_dq_i just before edge n+T_ACC is returned on rd_data.
- R3: A store accepted at edge n holds chip-select and the write strobe low for exactly T_WP cycles, with output-enable high throughout. It drives the request address and data from edge n. It keeps driving the data bus for one cycle after the write strobe rises, so the bus is driven for T_WP+1 cycles in total.
- R4: After a load, all strobes stay high for T_TURN cycles before the block goes idle. The data-bus output-enable is never high while output-enable is low, nor in the cycle right after output-enable was low.
- R5: Busy is high from the cycle after acceptance. It lasts T_ACC+T_TURN cycles for a load and T_WP+1 cycles for a store.
- R6: A request presented while busy is high is ignored. It neither lengthens the current access nor alters memory contents.
- R7: The write strobe is low only while chip-select is low.
- R8: rd_valid is high for exactly one cycle per load, in the cycle after edge n+T_ACC. It is never high for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | One-cycle request pulse, taken only when idle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle load-data strobe |
| rd_data | output | DW | Load data |
| mem_ce_n | output | 1 | Chip-select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output-enable, active low |
| mem_addr | output | AW | Memory address bus |
| mem_dq_o | output | DW | Data toward memory |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_o |
| mem_dq_i | input | DW | Data from memory |

## Verification
Every output is registered, so for a request sampled at edge n the strobes and address change right after edge n. Load data is valid in the cycle after edge n+T_ACC. Busy falls after edge n+T_ACC+T_TURN for a load and after edge n+T_WP+1 for a store. The bench drives and samples on falling edges and counts, cycle by cycle, how long each strobe, the bus enable and busy stay asserted, then compares those counts with the parameter sums above. A behavioural memory in the bench stores and returns nibbles and flags bus contention from the strobe history of the previous cycle. Back-to-back loads and stores then prove the data and the turnaround spacing together.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int AW     = 20,
  parameter int DW     = 4,
  parameter int T_ACC  = 2,
  parameter int T_WP   = 2,
  parameter int T_TURN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int TMAX = (T_ACC > T_WP) ? ((T_ACC > T_TURN) ? T_ACC : T_TURN)
                                       : ((T_WP > T_TURN) ? T_WP : T_TURN);
  localparam int CW = $clog2(TMAX + 2);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_REL, S_WR, S_HOLD} st_t;
  st_t           st;
  logic [CW-1:0] cnt;

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          if (req_we) begin
            st        <= S_WR;
            cnt       <= CW'(T_WP - 1);
            mem_we_n  <= 1'b0;
            mem_dq_o  <= req_wdata;
            mem_dq_oe <= 1'b1;
          end else begin
            st       <= S_RD;
            cnt      <= CW'(T_ACC - 1);
            mem_oe_n <= 1'b0;
          end
        end
        S_RD: if (cnt == '0) begin
          rd_data  <= mem_dq_i;
          rd_valid <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          st       <= S_REL;
          cnt      <= CW'(T_TURN - 1);
        end else cnt <= cnt - 1'b1;
        S_REL: if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - 1'b1;
        S_WR: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          mem_ce_n <= 1'b1;
          st       <= S_HOLD;
        end else cnt <= cnt - 1'b1;
        S_HOLD: begin
          mem_dq_oe <= 1'b0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CW-1:0] wp_len, ac_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_len <= '0;
      ac_len <= '0;
    end else begin
      wp_len <= mem_we_n ? '0 : wp_len + 1'b1;
      ac_len <= mem_oe_n ? '0 : ac_len + 1'b1;
    end
  end

  assert_wp_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> wp_len >= CW'(T_WP));
  assert_oe_off_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  assert_access_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ac_len >= CW'(T_ACC));
  assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));
  assert_we_in_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_valid_not_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mem_we_n && !mem_dq_oe));
endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
  localparam int T_ACC = 2, T_WP = 2, T_TURN = 1;

  logic clk = 0, rst_n = 0;
  logic req = 0, req_we = 0;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_wdata = '0;
  logic busy, rd_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [3:0] rd_data, mem_dq_o, mem_dq_i;
  logic [19:0] mem_addr;

  always #2.5 clk = ~clk;

  sram_ctl #(.AW(20), .DW(4), .T_ACC(T_ACC), .T_WP(T_WP), .T_TURN(T_TURN)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .mem_dq_i(mem_dq_i));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory, indexed by the low 6 address bits
  logic [3:0] mdl [64];
  logic prev_drv = 0;
  wire  drv = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = drv ? mdl[mem_addr[5:0]] : 4'h0;

  initial for (int i = 0; i < 64; i++) mdl[i] = 4'(i ^ 5);

  always @(negedge clk) if (rst_n) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) mdl[mem_addr[5:0]] <= mem_dq_o;
    if (mem_dq_oe && (drv || prev_drv)) chk(0, "R4 bus contention", 1, 0);
    if (!mem_we_n && mem_ce_n) chk(0, "R7 write strobe outside select", 1, 0);
    prev_drv <= drv;
  end

  task automatic op(input logic we, input logic [19:0] a, input logic [3:0] d,
                    input logic [3:0] ex);
    int nb = 0, nce = 0, noe = 0, nwe = 0, nde = 0, nv = 0;
    logic [3:0] got = 0;
    req = 1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 0;
    chk(mem_addr == a, we ? "R3 address" : "R2 address", mem_addr, a);
    while (busy && nb < 64) begin
      nb++;
      if (!mem_ce_n) nce++;
      if (!mem_oe_n) noe++;
      if (!mem_we_n) nwe++;
      if (mem_dq_oe) nde++;
      if (rd_valid) begin nv++; got = rd_data; end
      @(negedge clk);
    end
    if (we) begin
      chk(nwe == T_WP && nce == T_WP, "R3 write pulse", nwe, T_WP);
      chk(noe == 0, "R3 oe during write", noe, 0);
      chk(nde == T_WP + 1, "R3 data drive", nde, T_WP + 1);
      chk(nb == T_WP + 1, "R5 write busy", nb, T_WP + 1);
      chk(nv == 0, "R8 valid on write", nv, 0);
    end else begin
      chk(nce == T_ACC && noe == T_ACC && nwe == 0, "R2 read strobes", noe, T_ACC);
      chk(nde == 0, "R4 drive on read", nde, 0);
      chk(nb == T_ACC + T_TURN, "R5 R4 read busy", nb, T_ACC + T_TURN);
      chk(nv == 1, "R8 valid pulses", nv, 1);
      chk(got == ex, "R2 read data", got, ex);
    end
  endtask

  // {we, addr, wdata, expected}
  localparam logic [28:0] VEC [10] = '{
    {1'b1, 20'h12345, 4'hA, 4'h0},
    {1'b1, 20'hABC07, 4'h5, 4'h0},
    {1'b0, 20'h12345, 4'h0, 4'hA},
    {1'b1, 20'hFFFFF, 4'hF, 4'h0},
    {1'b0, 20'hABC07, 4'h0, 4'h5},
    {1'b0, 20'hFFFFF, 4'h0, 4'hF},
    {1'b1, 20'h00000, 4'h3, 4'h0},
    {1'b1, 20'h12345, 4'hC, 4'h0},
    {1'b0, 20'h00000, 4'h0, 4'h3},
    {1'b0, 20'h12345, 4'h0, 4'hC}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy && !rd_valid,
        "R1 reset outputs", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, busy, rd_valid}, 6'b111000);
    rst_n = 1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !busy,
        "R1 after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, busy}, 5'b11100);

    for (int i = 0; i < 10; i++)
      op(VEC[i][28], VEC[i][27:8], VEC[i][7:4], VEC[i][3:0]);

    // R6: second request while busy must be ignored
    begin
      int nb = 0;
      req = 1; req_we = 1; req_addr = 20'h00000; req_wdata = 4'h9;
      @(negedge clk);
      req = 1; req_we = 1; req_addr = 20'hFFFFF; req_wdata = 4'h0;
      @(negedge clk);
      req = 0;
      nb = 2;
      while (busy && nb < 64) begin nb++; @(negedge clk); end
      chk(nb == T_WP + 1 + 1, "R6 busy not extended", nb, T_WP + 2);
    end
    op(1'b0, 20'hFFFFF, 4'h0, 4'hF);
    op(1'b0, 20'h00000, 4'h0, 4'h9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule